// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five prioritised localities owns a shared command interface. Each locality has a one-byte access register that software writes to ask for ownership, give it up, or take it by force. The block also keeps one pointer that names the current owner. It answers reads of any locality's access register with a view that is built live. Each time a new owner takes over, it raises a one-cycle locality-changed event so that logic further on can post an interrupt.

Writes come in on a valid/ready channel. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. While the arbiter waits for the command engine to finish an abort, it holds `wr_ready` low, and the writer must keep its write steady until it is accepted. When ownership has to move while `cmd_busy` is high, the switch is not made at once. The arbiter raises `abort_req` and applies the switch in the cycle in which `abort_done` pulses. Reads are combinational: `rd_data` follows `rd_addr` and the current state.

Access register bits: bit 0 is the inverse of `established`; bit 1 is request-use; bit 2 is pending-request; bit 3 is seize (write only, always reads 0); bit 4 is been-seized; bit 5 is active; bit 7 is register-valid. Bit 6 reads 0. The locality is taken from address bits [14:12].

Top module: `locality_arbiter`

## Requirements
- R1: The locality is address bits [14:12]. Writes whose locality is 4, or whose locality is 5 to 7, change no state. Reads of locality 4 return its view in the normal way. Reads of localities 5 to 7 return 0x00.
- R2: After reset, `active_loc` is 0xFF, meaning no owner. Every locality then reads 0x80 when `established` is 1 and 0x81 when it is 0.
- R3: A write with bit 1 set from a locality that is not the owner has one of two effects. If there is no owner, that locality becomes the owner at once. Otherwise only its request-use flag is set.
- R4: When the owner writes bit 5, ownership passes to the highest-numbered locality whose request-use flag is set. If no locality is requesting, `active_loc` becomes 0xFF.
- R5: When a locality that is not the owner writes bit 5, the only effect is that its own request-use flag is cleared.
- R6: A write with bit 3 set is a seize. Within the same write it overrides bits 1 and 5. A seize takes ownership if there is no owner, or if the writer's number is higher than the owner's. Otherwise it has no effect.
- R7: When a seize displaces an owner, the old owner loses its active bit and has its been-seized bit set. When ownership passes by release instead, the old owner's active and request-use bits are cleared.
- R8: A new owner has its active bit set and its request-use and seize flags cleared. For one cycle after the switch, `loc_changed` is high and `loc_changed_id` names the new owner. A switch to no owner raises no event.
- R9: A read sets bit 2 when any locality other than the one read has request-use set. Bit 7 is always 1, and bit 3 always reads 0.
- R10: Writing 1 to bit 4 clears that locality's been-seized bit.
- R11: When `cmd_busy` is high as a switch is decided, `abort_req` rises and `wr_ready` falls, and `active_loc` holds its value. The switch takes effect on the clock edge at which `abort_done` is high. After that edge `abort_req` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write is offered |
| wr_ready | output | 1 | A write can be accepted; low while an abort is pending |
| wr_addr | input | 15 | Write address; bits [14:12] select the locality |
| wr_data | input | 8 | Byte written to the access register |
| rd_addr | input | 15 | Read address; bits [14:12] select the locality |
| rd_data | output | 8 | Live access register view |
| established | input | 1 | Established indication; its inverse appears in bit 0 |
| cmd_busy | input | 1 | The command engine is executing a command |
| abort_req | output | 1 | Asks the command engine to abort before ownership moves |
| abort_done | input | 1 | One-cycle pulse: the abort has finished |
| active_loc | output | 8 | Current owner, or 0xFF when there is none |
| loc_changed | output | 1 | One-cycle pulse: a new owner was installed |
| loc_changed_id | output | 3 | The owner named by the current pulse |

## Verification
The assertions assume that `abort_done` pulses only while `abort_req` is high. They also assume that `cmd_busy` stays steady while a write is being offered. The stimulus raises `abort_done` for exactly one cycle, and only after it has seen `abort_req` high. It changes `cmd_busy` only while no write is offered. Every write is driven on the falling edge, and the bench releases it right after the rising edge that accepts it, so no write is ever offered while `wr_ready` is low.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam logic [7:0] LOC_NONE = 8'hFF;
  localparam int BIT_NOEST  = 0;
  localparam int BIT_REQ    = 1;
  localparam int BIT_PEND   = 2;
  localparam int BIT_SEIZE  = 3;
  localparam int BIT_SEIZED = 4;
  localparam int BIT_ACT    = 5;
  localparam int BIT_VALID  = 7;
endpackage

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  // Ascending scan: the highest set index is the one that remains.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/loc_arb_view.sv
module loc_arb_view
  import loc_arb_pkg::*;
#(
  parameter int N  = 5,
  parameter int LW = 3
) (
  input  logic [LW-1:0] loc,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  seized,
  input  logic [N-1:0]  act_vec,
  input  logic          established,
  output logic [7:0]    value
);
  always_comb begin
    value = '0;
    if (int'(loc) < N) begin
      value[BIT_VALID] = 1'b1;
      value[BIT_NOEST] = ~established;
      for (int i = 0; i < N; i++) begin
        if (loc == LW'(i)) begin
          value[BIT_REQ]    = req[i];
          value[BIT_SEIZED] = seized[i];
          value[BIT_ACT]    = act_vec[i];
        end else if (req[i]) begin
          value[BIT_PEND] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC    = 5,
  parameter int ADDR_W     = 15,
  parameter int LOC_LSB    = 12,
  parameter int LOCKED_LOC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              established,
  input  logic              cmd_busy,
  output logic              abort_req,
  input  logic              abort_done,
  output logic [7:0]        active_loc,
  output logic              loc_changed,
  output logic [2:0]        loc_changed_id
);
  localparam int LW = ADDR_W - LOC_LSB;
  localparam int IW = 3;

  logic [7:0]         active_q, nxt_act, pend_tgt_q, nxt_tgt, sw_tgt, base_tgt, launch_tgt;
  logic [NUM_LOC-1:0] req_q, seize_q, seized_q, nxt_req, nxt_sz, nxt_bs, act_vec;
  logic               pend_q, nxt_pend, do_sw, launch, set_new, is_seize, higher_seize;
  logic               chg_d, act_valid;
  logic [7:0]         wv;
  logic [LW-1:0]      wloc;
  logic [7:0]         wloc8;
  logic               wr_fire, wr_ok;
  logic               pick_hit;
  logic [IW-1:0]      pick_idx;

  genvar g;
  generate
    for (g = 0; g < NUM_LOC; g++) begin : g_act
      assign act_vec[g] = (active_q == 8'(g));
    end
  endgenerate

  assign wloc      = wr_addr[LOC_LSB +: LW];
  assign wloc8     = 8'(wloc);
  assign wr_ready  = ~pend_q;
  assign wr_fire   = wr_valid & wr_ready;
  assign wr_ok     = (int'(wloc) < NUM_LOC) && (int'(wloc) != LOCKED_LOC);
  assign act_valid = active_q < 8'(NUM_LOC);
  assign abort_req = pend_q;
  assign active_loc = active_q;

  loc_arb_pick #(.N(NUM_LOC), .IW(IW)) u_pick (
    .vec(req_q), .hit(pick_hit), .idx(pick_idx)
  );

  loc_arb_view #(.N(NUM_LOC), .LW(LW)) u_view (
    .loc(rd_addr[LOC_LSB +: LW]), .req(req_q), .seized(seized_q),
    .act_vec(act_vec), .established(established), .value(rd_data)
  );

  always_comb begin
    nxt_req = req_q;  nxt_sz = seize_q;  nxt_bs = seized_q;
    nxt_act = active_q;  nxt_pend = pend_q;  nxt_tgt = pend_tgt_q;
    do_sw = 1'b0;  sw_tgt = active_q;  launch = 1'b0;  launch_tgt = LOC_NONE;
    set_new = 1'b0;  base_tgt = active_q;  wv = wr_data;
    higher_seize = 1'b0;  is_seize = 1'b0;  chg_d = 1'b0;

    if (pend_q && abort_done) begin
      do_sw = 1'b1;
      sw_tgt = pend_tgt_q;
      nxt_pend = 1'b0;
    end else if (wr_fire && wr_ok) begin
      set_new = 1'b1;
      if (wv[BIT_SEIZE]) begin
        wv[BIT_REQ] = 1'b0;
        wv[BIT_ACT] = 1'b0;
      end
      // release / withdraw
      if (wv[BIT_ACT]) begin
        if (active_q == wloc8) begin
          if (pick_hit) begin
            set_new = 1'b0;
            launch = 1'b1;
            launch_tgt = 8'(pick_idx);
          end else begin
            base_tgt = LOC_NONE;
          end
        end else begin
          nxt_req[wloc] = 1'b0;
        end
      end
      if (wv[BIT_SEIZED]) nxt_bs[wloc] = 1'b0;
      // seize
      for (int i = 0; i < NUM_LOC; i++)
        if (8'(i) > wloc8 && seize_q[i]) higher_seize = 1'b1;
      if (wv[BIT_SEIZE] && (!act_valid || wloc8 > active_q) &&
          !seize_q[wloc] && !higher_seize) begin
        for (int i = 0; i < NUM_LOC; i++)
          if (8'(i) < wloc8) nxt_sz[i] = 1'b0;
        nxt_sz[wloc] = 1'b1;
        set_new = 1'b0;
        launch = 1'b1;
        launch_tgt = wloc8;
      end
      // request
      if (wv[BIT_REQ] && active_q != wloc8) begin
        if (act_valid) nxt_req[wloc] = 1'b1;
        else base_tgt = wloc8;
      end
      if (set_new) begin
        do_sw = 1'b1;
        sw_tgt = base_tgt;
      end
      if (launch) begin
        if (cmd_busy) begin
          nxt_pend = 1'b1;
          nxt_tgt = launch_tgt;
        end else begin
          do_sw = 1'b1;
          sw_tgt = launch_tgt;
        end
      end
    end

    // install the new owner
    if (do_sw) begin
      for (int i = 0; i < NUM_LOC; i++)
        if (sw_tgt == 8'(i) && nxt_sz[i]) is_seize = 1'b1;
      if (sw_tgt != active_q) begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (active_q == 8'(i)) begin
            if (is_seize) nxt_bs[i] = 1'b1;
            else nxt_req[i] = 1'b0;
          end
        end
        chg_d = sw_tgt < 8'(NUM_LOC);
      end
      for (int i = 0; i < NUM_LOC; i++) begin
        if (sw_tgt == 8'(i)) begin
          nxt_req[i] = 1'b0;
          nxt_sz[i]  = 1'b0;
        end
      end
      nxt_act = sw_tgt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q       <= LOC_NONE;
      pend_tgt_q     <= LOC_NONE;
      pend_q         <= 1'b0;
      req_q          <= '0;
      seize_q        <= '0;
      seized_q       <= '0;
      loc_changed    <= 1'b0;
      loc_changed_id <= '0;
    end else begin
      active_q       <= nxt_act;
      pend_tgt_q     <= nxt_tgt;
      pend_q         <= nxt_pend;
      req_q          <= nxt_req;
      seize_q        <= nxt_sz;
      seized_q       <= nxt_bs;
      loc_changed    <= chg_d;
      loc_changed_id <= sw_tgt[IW-1:0];
    end
  end

  AST_OWNER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q < 8'(NUM_LOC)) || (active_q == LOC_NONE)); // R2
  AST_LOCKED_NEVER_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    active_q != 8'(LOCKED_LOC)); // R1
  AST_EVENT_NAMES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    loc_changed |-> (active_loc == 8'(loc_changed_id))); // R8
  AST_OWNER_FLAGS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_vec & req_q) == '0) && ((act_vec & seize_q) == '0)); // R8
  AST_HOLD_WHILE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !abort_done) |=> $stable(active_q)); // R11
  AST_SEIZE_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (seize_q != '0) |-> pend_q); // R11
endmodule

// File: tb/locality_arbiter_test.sv
module locality_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        established = 1'b1;
  logic        cmd_busy = 1'b0;
  logic        abort_req;
  logic        abort_done = 1'b0;
  logic [7:0]  active_loc;
  logic        loc_changed;
  logic [2:0]  loc_changed_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  locality_arbiter uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .established(established), .cmd_busy(cmd_busy), .abort_req(abort_req),
    .abort_done(abort_done), .active_loc(active_loc), .loc_changed(loc_changed),
    .loc_changed_id(loc_changed_id)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int loc, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = 15'(loc << 12);
    wr_data  = d;
    @(posedge clk);
    #2 wr_valid = 1'b0;
  endtask

  task automatic rd(input int loc, output logic [7:0] v);
    rd_addr = 15'(loc << 12);
    #1 v = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R2 owner after reset", active_loc, 8'hFF);
    rd(2, v); chk("R2 idle view est=1", v, 8'h80);
    established = 1'b0;
    rd(0, v); chk("R2 idle view est=0", v, 8'h81);
    established = 1'b1;
  endtask

  task automatic t_request;
    logic [7:0] v;
    wr(1, 8'h02);
    chk("R3 immediate grant", active_loc, 1);
    chk("R8 event pulse", loc_changed, 1);
    chk("R8 event id", loc_changed_id, 1);
    rd(1, v); chk("R8 owner view", v, 8'hA0);
    wr(3, 8'h02);
    chk("R3 queued request keeps owner", active_loc, 1);
    chk("R8 no event on queue", loc_changed, 0);
    rd(3, v); chk("R3 requester view", v, 8'h82);
    rd(1, v); chk("R9 pending on owner", v, 8'hA4);
    wr(2, 8'h02);
  endtask

  task automatic t_withdraw;
    logic [7:0] v;
    wr(2, 8'h20);
    chk("R5 owner unchanged", active_loc, 1);
    rd(2, v); chk("R5 request withdrawn", v, 8'h84);
    wr(2, 8'h02);
  endtask

  task automatic t_release;
    logic [7:0] v;
    wr(1, 8'h20);
    chk("R4 highest requester wins", active_loc, 3);
    chk("R8 event id on handover", loc_changed_id, 3);
    rd(1, v); chk("R7 old owner cleared", v, 8'h84);
    rd(3, v); chk("R8 new owner view", v, 8'hA4);
    wr(3, 8'h20);
    chk("R4 next requester", active_loc, 2);
    rd(3, v); chk("R7 handover clears", v, 8'h80);
    wr(2, 8'h20);
    chk("R4 none left", active_loc, 8'hFF);
    chk("R8 no event for none", loc_changed, 0);
  endtask

  task automatic t_locked;
    logic [7:0] v;
    wr(4, 8'h02);
    chk("R1 locked write ignored", active_loc, 8'hFF);
    rd(4, v); chk("R1 locked read works", v, 8'h80);
    wr(6, 8'h02);
    chk("R1 out of range write ignored", active_loc, 8'hFF);
    rd(6, v); chk("R1 out of range read", v, 8'h00);
  endtask

  task automatic t_seize;
    logic [7:0] v;
    wr(0, 8'h02);
    wr(1, 8'h02);
    wr(2, 8'h08);
    chk("R6 seize granted", active_loc, 2);
    chk("R8 event after seize", loc_changed_id, 2);
    rd(0, v); chk("R7 displaced marked", v, 8'h94);
    rd(2, v); chk("R9 seize bit hidden", v, 8'hA4);
    wr(1, 8'h08);
    chk("R6 lower seize ignored", active_loc, 2);
    chk("R6 no event", loc_changed, 0);
    wr(0, 8'h10);
    rd(0, v); chk("R10 been-seized cleared", v, 8'h84);
  endtask

  task automatic t_busy;
    logic [7:0] v;
    cmd_busy = 1'b1;
    wr(3, 8'h08);
    chk("R11 owner held", active_loc, 2);
    chk("R11 abort requested", abort_req, 1);
    chk("R11 writes stalled", wr_ready, 0);
    repeat (3) @(posedge clk);
    #2 chk("R11 still held", active_loc, 2);
    @(negedge clk); abort_done = 1'b1;
    @(posedge clk); #2 abort_done = 1'b0;
    cmd_busy = 1'b0;
    chk("R11 switch on done", active_loc, 3);
    chk("R11 abort cleared", abort_req, 0);
    chk("R11 event after abort", loc_changed_id, 3);
    rd(2, v); chk("R7 deferred seize marks", v, 8'h94);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_request();
    t_withdraw();
    t_release();
    t_locked();
    t_seize();
    t_busy();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule